// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel ports, called A and B, that can each act as source or destination. Each direction has a storage register. The A-to-B register captures the A port when its strobe rises. The B-to-A register captures the B port when its own strobe rises. Capture happens no matter how the outputs are set, so data can be stored while both ports are isolated.

One active-low output enable and one direction bit decide which port, if any, the block drives. For each direction, a select bit picks the source of the driven data: the live value on the opposite port, or the stored register. Driven data is always the bitwise inverse of the chosen source.

Each port is modelled as an input vector, an output vector and a per-bit drive-enable vector, so no tri-state pads are needed. The block runs on one system clock. The strobes are sampled as ordinary inputs, and a register loads on the clock edge at which its strobe is first seen high after being low.

Top module: `regxcvr`

## Requirements
- R1: While reset is asserted and after it is released, both drive-enable vectors are zero and both output vectors are zero. Both storage registers are cleared, so a stored-mode output reads all ones (the inverse of zero).
- R2: On a clock edge where `stb_ab` is 1 and it was 0 at the previous edge, the A-to-B register loads `a_in`. While `stb_ab` stays high, later edges do not reload the register.
- R3: On a clock edge where `stb_ba` is 1 and it was 0 at the previous edge, the B-to-A register loads `b_in`. While `stb_ba` stays high, later edges do not reload the register.
- R4: Capture into either register works the same for any value of `oe_n` and `dir`, including isolation.
- R5: When `oe_n` is 1, `a_oe`, `b_oe`, `a_out` and `b_out` are all zero.
- R6: When `oe_n` is 0 and `dir` is 1, `b_oe` is all ones and `a_oe` is zero.
- R7: When `oe_n` is 0 and `dir` is 0, `a_oe` is all ones and `b_oe` is zero.
- R8: On a driven port, a select of 0 drives the inverse of the live opposite-port input, and a select of 1 drives the inverse of that direction's register. `sel_ab` applies to B and `sel_ba` applies to A. The output vector of a port that is not driven is zero.
- R9: At no time are bits of `a_oe` and `b_oe` both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_n | input | 1 | Active-low output enable |
| dir | input | 1 | 1: drive B from A; 0: drive A from B |
| sel_ab | input | 1 | A-to-B source: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A source: 0 live, 1 stored |
| stb_ab | input | 1 | A-to-B capture strobe (rising transition) |
| stb_ba | input | 1 | B-to-A capture strobe (rising transition) |
| a_in | input | WIDTH | A port input value |
| a_out | output | WIDTH | A port driven value |
| a_oe | output | WIDTH | A port per-bit drive enable |
| b_in | input | WIDTH | B port input value |
| b_out | output | WIDTH | B port driven value |
| b_oe | output | WIDTH | B port per-bit drive enable |

## Verification
Directed cases come first. They cover the reset state read through stored mode, and capture while isolated and then read back. A strobe is held high across two edges with different data, which separates edge detection from level capture. Live and stored selects are applied while the opposite input differs from the register, so the two sources give different outputs. After that, random stimulus across every combination of enable, direction, select and strobe is checked against a bench model. That model tracks both registers and the previous strobe levels.

// File: rtl/regxcvr.sv
module regxcvr #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic             stb_ab,
  input  logic             stb_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe
);

  logic [WIDTH-1:0] reg_ab, reg_ba;
  logic             stb_ab_q, stb_ba_q;
  logic             live;

  wire load_ab = stb_ab & ~stb_ab_q;
  wire load_ba = stb_ba & ~stb_ba_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_ab_q <= 1'b0;
      stb_ba_q <= 1'b0;
      reg_ab   <= '0;
      reg_ba   <= '0;
      live     <= 1'b0;
    end else begin
      stb_ab_q <= stb_ab;
      stb_ba_q <= stb_ba;
      live     <= 1'b1;
      if (load_ab) reg_ab <= a_in;
      if (load_ba) reg_ba <= b_in;
    end
  end

  wire drive_b = live & ~oe_n & dir;
  wire drive_a = live & ~oe_n & ~dir;

  assign b_oe  = {WIDTH{drive_b}};
  assign a_oe  = {WIDTH{drive_a}};
  assign b_out = drive_b ? ~(sel_ab ? reg_ab : a_in) : '0;
  assign a_out = drive_a ? ~(sel_ba ? reg_ba : b_in) : '0;

  assert_capture_ab_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (live && stb_ab && !stb_ab_q) |=> (reg_ab == $past(a_in)));
  assert_hold_ab_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !(stb_ab && !stb_ab_q)) |=> $stable(reg_ab));
  assert_capture_ba_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && stb_ba && !stb_ba_q) |=> (reg_ba == $past(b_in)));
  assert_hold_ba_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !(stb_ba && !stb_ba_q)) |=> $stable(reg_ba));
  assert_isolate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0));
  assert_stored_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (b_oe[0] && sel_ab) |-> (b_out == ~reg_ab));
  assert_stored_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_oe[0] && sel_ba) |-> (a_out == ~reg_ba));
  assert_one_side_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !((|a_oe) && (|b_oe)));

endmodule

// File: tb/regxcvr_bench.sv
`timescale 1ns/1ps
module regxcvr_bench;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic stb_ab = 1'b0, stb_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic [W-1:0] m_ab = '0, m_ba = '0;
  logic p_ab = 1'b0, p_ba = 1'b0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  regxcvr #(.WIDTH(W)) u_regxcvr (.*);

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_b_oe(logic on);
    return (on && !oe_n && dir) ? '1 : '0;
  endfunction
  function automatic logic [W-1:0] exp_a_oe(logic on);
    return (on && !oe_n && !dir) ? '1 : '0;
  endfunction
  function automatic logic [W-1:0] exp_b_out();
    return (!oe_n && dir) ? ~(sel_ab ? m_ab : a_in) : '0;
  endfunction
  function automatic logic [W-1:0] exp_a_out();
    return (!oe_n && !dir) ? ~(sel_ba ? m_ba : b_in) : '0;
  endfunction

  task automatic check_all(string req);
    chk({req, " a_oe"}, a_oe, exp_a_oe(1'b1));
    chk({req, " b_oe"}, b_oe, exp_b_oe(1'b1));
    chk({req, " a_out"}, a_out, exp_a_out());
    chk({req, " b_out"}, b_out, exp_b_out());
  endtask

  task automatic step();
    if (stb_ab && !p_ab) m_ab = a_in;
    if (stb_ba && !p_ba) m_ba = b_in;
    p_ab = stb_ab; p_ba = stb_ba;
    @(negedge clk);
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234));
    oe_n = 1'b0; dir = 1'b1;
    @(negedge clk); #1;
    chk("R1 oe in reset", b_oe, '0);
    chk("R1 out in reset", b_out, '0);
    oe_n = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 a_oe after reset", a_oe, '0);
    chk("R1 b_oe after reset", b_oe, '0);
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; #1;
    chk("R1 cleared reg_ab", b_out, 8'hFF);
    dir = 1'b0; sel_ba = 1'b1; #1;
    chk("R1 cleared reg_ba", a_out, 8'hFF);
    chk("R7 a_oe", a_oe, '1);
    chk("R7 b_oe", b_oe, '0);

    // R4: capture while isolated
    oe_n = 1'b1; a_in = 8'h3C; b_in = 8'hA5; stb_ab = 1'b1; stb_ba = 1'b1; #1;
    chk("R5 isolated a_out", a_out, '0);
    chk("R5 isolated b_oe", b_oe, '0);
    step();
    stb_ab = 1'b0; stb_ba = 1'b0; a_in = 8'h00; b_in = 8'hFF;
    step();
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; #1;
    chk("R4 R2 stored ab", b_out, 8'hC3);
    chk("R6 b_oe", b_oe, '1);
    chk("R6 a_oe", a_oe, '0);
    sel_ab = 1'b0; #1;
    chk("R8 live ab", b_out, 8'hFF);
    dir = 1'b0; sel_ba = 1'b1; #1;
    chk("R4 R3 stored ba", a_out, 8'h5A);
    sel_ba = 1'b0; #1;
    chk("R8 live ba", a_out, 8'h00);

    // R2: held strobe must not reload
    a_in = 8'h11; stb_ab = 1'b1; step();
    a_in = 8'h22; step();
    stb_ab = 1'b0; step();
    dir = 1'b1; sel_ab = 1'b1; #1;
    chk("R2 held strobe", b_out, 8'hEE);
    // R3: held strobe must not reload
    b_in = 8'h44; stb_ba = 1'b1; step();
    b_in = 8'h88; step();
    stb_ba = 1'b0; step();
    dir = 1'b0; sel_ba = 1'b1; #1;
    chk("R3 held strobe", a_out, 8'hBB);

    for (int i = 0; i < 3000; i++) begin
      {oe_n, dir, sel_ab, sel_ba, stb_ab, stb_ba} = 6'($urandom);
      a_in = W'($urandom); b_in = W'($urandom);
      #1;
      check_all("R5 R6 R7 R8 random");
      checks++;
      if ((|a_oe) && (|b_oe)) begin
        errors++;
        $display("FAIL R9 actual %h/%h expected one side", a_oe, b_oe);
      end
      step();
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule